// File: doc/BRIEF.md
# Two-Phase to Four-Phase Handshake Bridge

This block joins a transition-signalling channel to a level-signalling channel. On the transition-signalling side, every change of the request wire stands for one transfer. A rise and a fall both count. Every change of the acknowledge wire closes that transfer, and the channel is at rest whenever the two wires carry the same level. On the level-signalling side, each transfer takes four events: the request goes high, the acknowledge goes high, the request goes low, and the acknowledge goes low. The second half of that exchange moves no data, but it must finish before the next transfer can begin.

For each toggle of the incoming request, the bridge captures the data word that travels with it. It raises the outgoing request with that word held on its output, then runs the whole return-to-zero sequence. It answers the transition side with a single acknowledge toggle only after the level-side acknowledge has dropped. A request that is waiting when a cycle ends is seen by comparing levels, so it is launched on the very next clock edge.

All handshake inputs are sampled on the rising clock edge and are assumed to be synchronous to the clock. The bridge neither produces data nor checks timing margins.

Top module: `toggle_level_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lv_req`, `tg_ack` and `lv_data` are all 0, and the bridge launches nothing while `tg_req` equals `tg_ack`.
- R2: When the bridge is idle and samples `tg_req` different from `tg_ack` on a rising edge, `lv_req` goes to 1 at that edge and `lv_data` takes the value of `tg_data` sampled there. A rising toggle of `tg_req` and a falling one both launch.
- R3: Once raised, `lv_req` stays at 1 until `lv_ack` is sampled at 1, and it falls at that edge.
- R4: `tg_ack` keeps its level while `lv_ack` is still 1 after `lv_req` has fallen. It inverts at the first edge where `lv_ack` is sampled at 0.
- R5: `lv_data` does not change from the rise of `lv_req` until `lv_ack` rises; changes on `tg_data` after launch have no effect on it.
- R6: Each toggle of `tg_req` produces exactly one rise of `lv_req` and exactly one inversion of `tg_ack`.
- R7: If `tg_req` already differs from `tg_ack` on the edge right after `tg_ack` inverts, `lv_req` rises at that edge, so a waiting request is never lost or delayed.
- R8: `lv_req` does not rise again while `lv_ack` is still 1 from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tg_req | input | 1 | Transition-signalling request; each change starts a transfer |
| tg_data | input | W | Data word bundled with `tg_req` |
| tg_ack | output | 1 | Transition-signalling acknowledge; inverts once per finished transfer |
| lv_req | output | 1 | Level-signalling request |
| lv_ack | input | 1 | Level-signalling acknowledge |
| lv_data | output | W | Captured data word presented with `lv_req` |

## Verification
Every result takes a single register stage. A launch shows on `lv_req` and `lv_data` right after the edge that samples the request toggle. The fall of `lv_req` follows the edge that samples `lv_ack` high, and the inversion of `tg_ack` follows the edge that samples `lv_ack` low. The bench drives inputs on falling edges and reads outputs on the next falling edge, half a period after the edge where each result is due. The directed checks hold the acknowledges for extra cycles to confirm that nothing moves early. A randomized sweep then varies both sides' response delays from zero to several cycles, and the bench counts request rises and acknowledge inversions against the number of transfers.

// File: rtl/toggle_level_bridge.sv
module toggle_level_bridge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tg_req,
  input  logic [W-1:0] tg_data,
  output logic         tg_ack,
  output logic         lv_req,
  input  logic         lv_ack,
  output logic [W-1:0] lv_data
);

  typedef enum logic [1:0] {IDLE, HOLD, DRAIN} st_t;
  st_t st;

  logic pending;
  assign pending = tg_req ^ tg_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      lv_req  <= 1'b0;
      tg_ack  <= 1'b0;
      lv_data <= '0;
    end else begin
      case (st)
        IDLE: if (pending) begin
          lv_data <= tg_data;
          lv_req  <= 1'b1;
          st      <= HOLD;
        end
        HOLD: if (lv_ack) begin
          lv_req <= 1'b0;
          st     <= DRAIN;
        end
        DRAIN: if (!lv_ack) begin
          tg_ack <= ~tg_ack;
          st     <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && pending) |=> (lv_req && lv_data == $past(tg_data)));

  a_r3_req_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_req && !lv_ack) |=> lv_req);

  a_r8_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_req && lv_ack) |=> !lv_req);

  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_req && !lv_ack) |=> $stable(lv_data));

  a_r4_ack_after_rtz: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_ack != $past(tg_ack)) |-> (!lv_req && !$past(lv_ack)));

  a_r6_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_ack != $past(tg_ack)) |=> (tg_ack == $past(tg_ack)));

endmodule

// File: tb/toggle_level_bridge_test.sv
module toggle_level_bridge_test;
  localparam int W = 8;
  localparam int NRAND = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tg_req = 1'b0;
  logic [W-1:0] tg_data = '0;
  logic tg_ack, lv_req;
  logic [W-1:0] lv_data;
  logic lv_ack;
  logic dir_ack = 1'b0;
  logic rx_ack = 1'b0;
  logic rx_on = 1'b0;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  int toggles = 0;
  int rx_count = 0;
  int cyc = 0;
  logic prev_req = 1'b0;
  logic prev_ack = 1'b0;

  assign lv_ack = rx_on ? rx_ack : dir_ack;

  always #2.5 clk = ~clk;

  toggle_level_bridge #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tg_req(tg_req), .tg_data(tg_data),
    .tg_ack(tg_ack), .lv_req(lv_req), .lv_ack(lv_ack), .lv_data(lv_data)
  );

  function automatic logic [W-1:0] word(int k);
    return W'((k * 37 + 5) ^ (k >> 2));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (lv_req && !prev_req) rises++;
      if (tg_ack != prev_ack) toggles++;
    end
    prev_req = lv_req;
    prev_ack = tg_ack;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : receiver
    wait (rx_on);
    forever begin
      @(negedge clk);
      if (lv_req) begin
        for (int d = $urandom_range(0, 4); d > 0; d--) @(negedge clk);
        chk("R5 data", lv_data, word(rx_count));
        rx_ack = 1'b1;
        do @(negedge clk); while (lv_req);
        for (int d = $urandom_range(0, 4); d > 0; d--) @(negedge clk);
        rx_ack = 1'b0;
        rx_count++;
      end
    end
  end

  initial begin : main
    int r0, t0;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk("R1 lv_req in reset", lv_req, 0);
    chk("R1 tg_ack in reset", tg_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lv_req after reset", lv_req, 0);
    chk("R1 lv_data after reset", lv_data, 0);
    repeat (3) @(negedge clk);
    chk("R1 no launch when levels equal", lv_req, 0);

    tg_data = 8'hA5;
    tg_req = 1'b1;
    @(negedge clk);
    chk("R2 rise launches", lv_req, 1);
    chk("R2 data captured", lv_data, 8'hA5);
    chk("R2 ack not yet", tg_ack, 0);
    tg_data = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 req held", lv_req, 1);
      chk("R5 data held", lv_data, 8'hA5);
    end
    dir_ack = 1'b1;
    @(negedge clk);
    chk("R3 req falls on ack", lv_req, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R4 ack waits rtz", tg_ack, 0);
      chk("R8 no early rise", lv_req, 0);
    end
    dir_ack = 1'b0;
    @(negedge clk);
    chk("R4 ack toggles", tg_ack, 1);
    chk("R4 req low", lv_req, 0);

    tg_data = 8'h5A;
    tg_req = 1'b0;
    @(negedge clk);
    chk("R7 back-to-back launch", lv_req, 1);
    chk("R2 falling toggle data", lv_data, 8'h5A);
    dir_ack = 1'b1;
    @(negedge clk);
    dir_ack = 1'b0;
    @(negedge clk);
    chk("R4 second toggle", tg_ack, 0);
    repeat (2) @(negedge clk);
    chk("R6 no extra launch", lv_req, 0);

    r0 = rises;
    t0 = toggles;
    rx_on = 1'b1;
    for (int k = 0; k < NRAND; k++) begin
      tg_data = word(k);
      tg_req = ~tg_req;
      do @(negedge clk); while (tg_ack != tg_req);
      for (int d = $urandom_range(0, 3); d > 0; d--) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R6 rises per toggle", rises - r0, NRAND);
    chk("R6 acks per toggle", toggles - t0, NRAND);
    chk("R6 receiver count", rx_count, NRAND);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule